// File: doc/BRIEF.md
# Processor Timer Control, Status and Decrementer

This block is the timer facility next to a processor core. It holds a 32-bit control register and a 32-bit status register, and it runs a down-counter that moves one step on each time-base tick. The core writes the control register, the status register, the counter and a separate reload register through one register write port. All four registers share that port, and a 2-bit select picks the target.

When the counter passes from 1 to 0 it latches a status flag. If automatic reload is enabled, it restarts from the reload register. Otherwise it stays at zero. Event pulses for the fixed-interval and watchdog timers come from a tap generator outside this block, and each pulse sets its own status bits. Three level-sensitive interrupt lines each follow a status bit gated by an enable bit in the control register. The watchdog staging is reported in status only. No reset is forced.

Top module: `core_timer_unit`

## Requirements
- R1: After a synchronous active-low reset, the control register, the status register and the counter read 0, and all three interrupt lines are low.
- R2: A write with select 0 stores all 32 data bits in the control register. Control fields: bits 31:30 watchdog period, 29:28 watchdog reset control, 27 watchdog interrupt enable, 26 counter interrupt enable, 25:24 fixed-interval period, 23 fixed-interval interrupt enable, 22 automatic reload enable.
- R3: A write with select 1 clears each status bit that is 1 in the data and keeps every other bit. Status fields: bit 31 watchdog armed, 30 watchdog interrupt, 29:28 watchdog reset report, 27 counter expired, 26 fixed-interval event. All other status bits read 0.
- R4: If a status bit is set by an event and cleared by a write in the same cycle, the bit ends up set.
- R5: The counter interrupt is status bit 27 AND control bit 26. The fixed-interval interrupt is status bit 26 AND control bit 23. The watchdog interrupt is status bit 30 AND control bit 27. Each line follows its registers in the cycle after they change.
- R6: The counter changes only on a cycle with a tick. On a tick with no pending load it decrements by one if it is nonzero.
- R7: A write with select 2 is held pending. It does not change the counter until the first tick after the write cycle, and that tick loads the written value.
- R8: A tick that moves the counter from 1 to 0 sets status bit 27. With automatic reload disabled, the counter then stays at 0.
- R9: A write with select 3 sets the reload value. On expiry with control bit 22 set, the counter loads the reload value instead of 0.
- R10: A fixed-interval event pulse sets status bit 26.
- R11: The action of a watchdog event pulse depends on status. If bit 31 is clear, the pulse sets bit 31. If bit 31 is set and bit 30 is clear, it sets bit 30. If both are set and bits 29:28 are zero, it copies control bits 29:28 into status bits 29:28.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tb_tick | input | 1 | Time-base tick, one cycle per count |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 status, 2 counter, 3 reload |
| wr_data | input | 32 | Write data |
| fit_evt | input | 1 | Fixed-interval event pulse |
| wdt_evt | input | 1 | Watchdog event pulse |
| ctrl_q | output | 32 | Control register value |
| stat_q | output | 32 | Status register value |
| dec_q | output | 32 | Counter value |
| irq_dec | output | 1 | Counter interrupt |
| irq_fit | output | 1 | Fixed-interval interrupt |
| irq_wdt | output | 1 | Watchdog interrupt |

## Verification
Each register shows on an output, so a wrong control or status bit appears one cycle after the write or event that caused it. A missed or duplicated expiry appears at the next tick as a counter value off by one, or as a reload that never happens. A pending counter write that is lost or applied early is hidden until the first tick after the write. The bench therefore holds such writes across several idle cycles before it ticks.

// File: rtl/ctu_pkg.sv
`timescale 1ns/1ps
// ctu_pkg: shared field positions and write-select codes for the timer unit.
// Assumes 32-bit control and status registers with fixed field positions.
package ctu_pkg;
    localparam int REG_W = 32;

    // control register fields
    localparam int C_WRC_LO = 28;
    localparam int C_WIE    = 27;
    localparam int C_DIE    = 26;
    localparam int C_FIE    = 23;
    localparam int C_ARE    = 22;

    // status register fields
    localparam int S_ENW    = 31;
    localparam int S_WIS    = 30;
    localparam int S_WRS_LO = 28;
    localparam int S_DIS    = 27;
    localparam int S_FIS    = 26;
    localparam logic [REG_W-1:0] S_IMPL = 32'hFC00_0000;

    // interrupt vector order
    localparam int IRQ_N   = 3;
    localparam int IRQ_DEC = 0;
    localparam int IRQ_FIT = 1;
    localparam int IRQ_WDT = 2;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_STAT   = 2'd1,
        SEL_DEC    = 2'd2,
        SEL_RELOAD = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/ctu_dec.sv
`timescale 1ns/1ps
// ctu_dec: tick-driven down-counter with a deferred direct load and an
// optional reload on expiry. Assumes at most one tick per clock cycle.
module ctu_dec #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         ld_cnt,
    input  logic         ld_rel,
    input  logic [W-1:0] wdata,
    input  logic         auto_rel,
    output logic [W-1:0] cnt,
    output logic         expire
);
    localparam logic [W-1:0] ONE = W'(1);

    logic         pend;
    logic [W-1:0] pend_val;
    logic [W-1:0] rel_val;

    // expiry: a tick that carries the counter from 1 down to 0
    always_comb expire = tick && !pend && (cnt == ONE);

    // counter update, applied only on ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tick) begin
            if (pend)
                cnt <= pend_val;
            else if (expire && auto_rel)
                cnt <= rel_val;
            else if (cnt != '0)
                cnt <= cnt - ONE;
        end
    end

    // pending direct load, consumed by the next tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend     <= 1'b0;
            pend_val <= '0;
        end else if (ld_cnt) begin
            pend     <= 1'b1;
            pend_val <= wdata;
        end else if (tick) begin
            pend     <= 1'b0;
        end
    end

    // reload register
    always_ff @(posedge clk) begin
        if (!rst_n)
            rel_val <= '0;
        else if (ld_rel)
            rel_val <= wdata;
    end
endmodule

// File: rtl/ctu_status.sv
`timescale 1ns/1ps
// ctu_status: status register with write-one-to-clear and event set. When an
// event and a clear hit the same bit, the set wins. The watchdog stages
// armed -> interrupt -> reset report.
module ctu_status
    import ctu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_en,
    input  logic [REG_W-1:0] clr_mask,
    input  logic             dec_evt,
    input  logic             fit_evt,
    input  logic             wdt_evt,
    input  logic [1:0]       wrc,
    output logic [REG_W-1:0] stat
);
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] clr_vec;

    // bits to set this cycle from events
    always_comb begin
        set_vec          = '0;
        set_vec[S_DIS]   = dec_evt;
        set_vec[S_FIS]   = fit_evt;
        if (wdt_evt) begin
            if (!stat[S_ENW])
                set_vec[S_ENW] = 1'b1;
            else if (!stat[S_WIS])
                set_vec[S_WIS] = 1'b1;
            else if (stat[S_WRS_LO +: 2] == 2'b00)
                set_vec[S_WRS_LO +: 2] = wrc;
        end
    end

    // bits to clear this cycle from a status write
    always_comb clr_vec = clr_en ? (clr_mask & S_IMPL) : '0;

    // status register update
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat <= '0;
        else
            stat <= ((stat & ~clr_vec) | set_vec) & S_IMPL;
    end
endmodule

// File: rtl/ctu_irq.sv
`timescale 1ns/1ps
// ctu_irq: gates each status flag with its enable to form a level interrupt.
// Assumes the flag and enable vectors are aligned index by index.
module ctu_irq #(
    parameter int N = 3
) (
    input  logic [N-1:0] flag,
    input  logic [N-1:0] en,
    output logic [N-1:0] irq
);
    for (genvar i = 0; i < N; i++) begin : g_gate
        // one interrupt line per source
        assign irq[i] = flag[i] & en[i];
    end
endmodule

// File: rtl/core_timer_unit.sv
`timescale 1ns/1ps
// core_timer_unit: processor timer facility. It holds the control register,
// the status register, the down-counter and its reload value, and drives
// three level interrupts. Fixed-interval and watchdog pulses are generated
// outside the block.
module core_timer_unit
    import ctu_pkg::*;
#(
    parameter int DEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tb_tick,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             fit_evt,
    input  logic             wdt_evt,
    output logic [REG_W-1:0] ctrl_q,
    output logic [REG_W-1:0] stat_q,
    output logic [DEC_W-1:0] dec_q,
    output logic             irq_dec,
    output logic             irq_fit,
    output logic             irq_wdt
);
    logic             wr_ctrl, wr_stat, wr_cnt, wr_rel;
    logic             dec_expire;
    logic [IRQ_N-1:0] flag_v, en_v, irq_v;

    // write select decode
    always_comb begin
        wr_ctrl = wr_en && (wr_sel == SEL_CTRL);
        wr_stat = wr_en && (wr_sel == SEL_STAT);
        wr_cnt  = wr_en && (wr_sel == SEL_DEC);
        wr_rel  = wr_en && (wr_sel == SEL_RELOAD);
    end

    // control register
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_ctrl)
            ctrl_q <= wr_data;
    end

    ctu_dec #(.W(DEC_W)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tb_tick),
        .ld_cnt   (wr_cnt),
        .ld_rel   (wr_rel),
        .wdata    (wr_data[DEC_W-1:0]),
        .auto_rel (ctrl_q[C_ARE]),
        .cnt      (dec_q),
        .expire   (dec_expire)
    );

    ctu_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_en   (wr_stat),
        .clr_mask (wr_data),
        .dec_evt  (dec_expire),
        .fit_evt  (fit_evt),
        .wdt_evt  (wdt_evt),
        .wrc      (ctrl_q[C_WRC_LO +: 2]),
        .stat     (stat_q)
    );

    // align status flags and enables for the gating stage
    always_comb begin
        flag_v[IRQ_DEC] = stat_q[S_DIS];
        flag_v[IRQ_FIT] = stat_q[S_FIS];
        flag_v[IRQ_WDT] = stat_q[S_WIS];
        en_v[IRQ_DEC]   = ctrl_q[C_DIE];
        en_v[IRQ_FIT]   = ctrl_q[C_FIE];
        en_v[IRQ_WDT]   = ctrl_q[C_WIE];
    end

    ctu_irq #(.N(IRQ_N)) u_irq (
        .flag (flag_v),
        .en   (en_v),
        .irq  (irq_v)
    );

    assign irq_dec = irq_v[IRQ_DEC];
    assign irq_fit = irq_v[IRQ_FIT];
    assign irq_wdt = irq_v[IRQ_WDT];
endmodule

// File: rtl/ctu_checker.sv
`timescale 1ns/1ps
// ctu_checker: temporal properties of the timer unit, bound to the top.
module ctu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        tb_tick,
    input logic        fit_evt,
    input logic        wdt_evt,
    input logic [31:0] ctrl_q,
    input logic [31:0] stat_q,
    input logic [31:0] dec_q,
    input logic        irq_dec,
    input logic        irq_fit,
    input logic        irq_wdt
);
    logic was_rst = 1'b0;

    // remember whether reset was applied at the previous edge
    always_ff @(posedge clk) was_rst <= !rst_n;

    // R1: registers are cleared after a reset edge
    always @(posedge clk) begin
        if (was_rst)
            assert_reset_clear_R1: assert (ctrl_q == 32'd0 && stat_q == 32'd0 && dec_q == 32'd0
                                           && !irq_dec && !irq_fit && !irq_wdt);
    end

    // R5: each interrupt line matches its status and enable bits
    assert_irq_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_dec == (stat_q[27] & ctrl_q[26])) && (irq_fit == (stat_q[26] & ctrl_q[23]))
        && (irq_wdt == (stat_q[30] & ctrl_q[27])));

    // R6: without a tick the counter holds
    assert_hold_no_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !tb_tick |=> $stable(dec_q));

    // R8: the expired flag rises only after a tick
    assert_expire_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[27]) |-> $past(tb_tick));

    // R10 and R4: a fixed-interval pulse always leaves its flag set
    assert_fit_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fit_evt |=> stat_q[26]);

    // R11: the watchdog armed flag rises only after a watchdog pulse
    assert_wdt_arm_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[31]) |-> $past(wdt_evt));
endmodule

bind core_timer_unit ctu_checker u_chk (.*);

// File: tb/core_timer_unit_test.sv
`timescale 1ns/1ps
// core_timer_unit_test: directed corner cases followed by seeded random
// traffic. Every cycle is compared with a reference model in the bench.
module core_timer_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tb_tick = 1'b0, wr_en = 1'b0, fit_evt = 1'b0, wdt_evt = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic [31:0] ctrl_q, stat_q, dec_q;
    logic        irq_dec, irq_fit, irq_wdt;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    // reference model state
    logic [31:0] m_ctrl = 0, m_stat = 0, m_dec = 0, m_rel = 0, m_pval = 0;
    bit          m_pend = 0;

    core_timer_unit uut (
        .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .fit_evt(fit_evt), .wdt_evt(wdt_evt), .ctrl_q(ctrl_q),
        .stat_q(stat_q), .dec_q(dec_q), .irq_dec(irq_dec), .irq_fit(irq_fit),
        .irq_wdt(irq_wdt)
    );

    always #10 clk = ~clk;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] m_irq();
        return {m_stat[30] & m_ctrl[27], m_stat[26] & m_ctrl[23], m_stat[27] & m_ctrl[26]};
    endfunction

    // model of one clock edge, built from the requirements
    task automatic model_edge(bit t, bit we, logic [1:0] s, logic [31:0] d, bit f, bit w);
        logic [31:0] set_v, clr_v;
        bit expire;
        expire = t && !m_pend && (m_dec == 32'd1);
        set_v = 0;
        set_v[27] = expire;                                   // R8
        set_v[26] = f;                                        // R10
        if (w) begin                                          // R11
            if (!m_stat[31]) set_v[31] = 1;
            else if (!m_stat[30]) set_v[30] = 1;
            else if (m_stat[29:28] == 2'b00) set_v[29:28] = m_ctrl[29:28];
        end
        clr_v = (we && s == 2'd1) ? d : 32'd0;                // R3
        if (t) begin                                          // R6, R7, R9
            if (m_pend) m_dec = m_pval;
            else if (expire && m_ctrl[22]) m_dec = m_rel;
            else if (m_dec != 0) m_dec = m_dec - 1;
        end
        if (we && s == 2'd2) begin m_pend = 1; m_pval = d; end
        else if (t) m_pend = 0;
        m_stat = ((m_stat & ~clr_v) | set_v) & 32'hFC00_0000; // R4
        if (we && s == 2'd3) m_rel = d;
        if (we && s == 2'd0) m_ctrl = d;                      // R2
    endtask

    task automatic step(bit t, bit we, logic [1:0] s, logic [31:0] d, bit f, bit w);
        tb_tick = t; wr_en = we; wr_sel = s; wr_data = d; fit_evt = f; wdt_evt = w;
        @(posedge clk);
        model_edge(t, we, s, d, f, w);
        @(negedge clk);
        tb_tick = 0; wr_en = 0; fit_evt = 0; wdt_evt = 0;
        chk("R2 control", ctrl_q, m_ctrl);
        chk("R3 status", stat_q, m_stat);
        chk("R6 counter", dec_q, m_dec);
        chk("R5 irq", {29'd0, irq_wdt, irq_fit, irq_dec}, {29'd0, m_irq()});
    endtask

    task automatic idle(); step(0, 0, 2'd0, 0, 0, 0); endtask
    task automatic tick(); step(1, 0, 2'd0, 0, 0, 0); endtask
    task automatic wr(logic [1:0] s, logic [31:0] d); step(0, 1, s, d, 0, 0); endtask

    // run watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 ctrl", ctrl_q, 0); chk("R1 stat", stat_q, 0); chk("R1 dec", dec_q, 0);
        chk("R1 irq", {29'd0, irq_wdt, irq_fit, irq_dec}, 0);

        // R7: deferred counter load
        wr(2'd2, 32'd5); idle(); idle();
        chk("R7 held before tick", dec_q, 0);
        tick(); chk("R7 loaded on tick", dec_q, 5);
        tick(); chk("R6 one step", dec_q, 4);

        // R8: expiry without reload, counter interrupt enabled
        wr(2'd0, 32'h0400_0000);
        repeat (4) tick();
        chk("R8 reaches zero", dec_q, 0);
        chk("R8 flag set", stat_q, 32'h0800_0000);
        chk("R5 counter irq", {31'd0, irq_dec}, 1);
        tick(); chk("R8 stays zero", dec_q, 0);
        wr(2'd1, 32'h0800_0000);
        chk("R3 cleared", stat_q, 0);

        // R9: reload on expiry
        wr(2'd3, 32'd3); wr(2'd0, 32'h0440_0000);
        wr(2'd2, 32'd1); tick(); chk("R9 loaded one", dec_q, 1);
        tick(); chk("R9 reloaded", dec_q, 3);
        chk("R9 flag", stat_q, 32'h0800_0000);

        // R10, R3, R4: fixed-interval event, partial clear, set beats clear
        step(0, 0, 2'd0, 0, 1, 0);
        chk("R10 fit flag", stat_q, 32'h0C00_0000);
        wr(2'd1, 32'h0800_0000);
        chk("R3 other bit kept", stat_q, 32'h0400_0000);
        step(0, 1, 2'd1, 32'h0400_0000, 1, 0);
        chk("R4 set wins", stat_q, 32'h0400_0000);

        // R11: watchdog staging
        wr(2'd1, 32'hFFFF_FFFF); wr(2'd0, 32'h2800_0000);
        step(0, 0, 2'd0, 0, 0, 1); chk("R11 armed", stat_q, 32'h8000_0000);
        step(0, 0, 2'd0, 0, 0, 1); chk("R11 interrupt", stat_q, 32'hC000_0000);
        chk("R5 watchdog irq", {31'd0, irq_wdt}, 1);
        step(0, 0, 2'd0, 0, 0, 1); chk("R11 report", stat_q, 32'hE000_0000);
        step(0, 0, 2'd0, 0, 0, 1); chk("R11 saturated", stat_q, 32'hE000_0000);

        // random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            logic [1:0]  s;
            logic [31:0] d;
            s = 2'($urandom_range(0, 3));
            d = $urandom();
            if (s == 2'd2 || s == 2'd3) d = d & 32'h7;
            if (s == 2'd1 && ($urandom_range(0, 1) == 0)) d = d & 32'hFC00_0000;
            step($urandom_range(0, 1) == 1, $urandom_range(0, 9) < 3, s, d,
                 $urandom_range(0, 19) == 0, $urandom_range(0, 19) == 0);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule